// File: doc/BRIEF.md
# Per-Channel Blocking Pulse Generator

This block turns a per-timeslot selection mask into a gating level for a 24-channel T1 framed stream. The level can block the clock of a downstream HDLC or UART controller so that the controller only sees the timeslots it owns. The receive side and the transmit side are fully separate. Each has its own bit strobe, its own frame sync, its own mask and its own output.

Each side counts bit positions in a 193-bit frame. Position 0 is the F-bit, and channel k occupies positions 8k-7 through 8k. A frame sync that arrives with a bit strobe puts the counter back on the F-bit. Software writes the mask as three byte-wide registers per side into a staging copy. The staging copy moves into the working mask only when the counter enters the F-bit, so a channel window is never cut short or stretched.

Top module: `chgate_top`

## Requirements
- R1: After a synchronous active-low reset, all staged and working masks are zero, both position counters are at the F-bit (position 0), and both outputs are low.
- R2: Receive mask bytes are at addresses 0x6C, 0x6D and 0x6E, and transmit mask bytes are at 0x32, 0x33 and 0x34. Channel n (1..24) is controlled by byte (n-1)/8 of its side, at bit (n-1)%8 of that byte, counting from the least significant bit.
- R3: When the working mask bit of a channel is 1, the output is high at every one of that channel's eight positions.
- R4: When the working mask bit of a channel is 0, the output is low at every one of that channel's eight positions.
- R5: The output is low whenever the position counter is at the F-bit (position 0).
- R6: A bit strobe that comes with frame sync sets the position to 0, whatever the current position is.
- R7: A bit strobe without frame sync advances the position by one, and wraps from 192 to 0. Without a bit strobe the position does not change.
- R8: Staged mask bytes are copied to the working mask only on a bit strobe that sets the position to 0. A byte written in that same cycle takes effect at the following frame boundary.
- R9: A write changes only the one byte it addresses on its own side. Writes to any other address change neither side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rx_bit_en | input | 1 | Receive bit strobe, one per bit time |
| rx_fsync | input | 1 | Receive frame sync, marks the F-bit when strobed |
| tx_bit_en | input | 1 | Transmit bit strobe, one per bit time |
| tx_fsync | input | 1 | Transmit frame sync, marks the F-bit when strobed |
| rx_blk | output | 1 | Receive channel gating level |
| tx_blk | output | 1 | Transmit channel gating level |

## Verification
The position counter, the staged mask and the working mask are all registered on the same edge that samples a strobe or a write. The output is a combinational decode of the counter and the working mask, so every effect is due one clock after the stimulus that causes it. The bench drives inputs on the falling edge. A reference model updates on the rising edge from the stated rules, and the outputs are compared against that model on the next falling edge, which is exactly one cycle after each stimulus. Writes that coincide with a frame boundary are produced on purpose, to confirm the one-frame deferral.

// File: rtl/chgate_pkg.sv
// Package: shared constants for the channel gating block.
// Assumes a T1 frame: 24 channels of 8 bits plus one framing bit.
package chgate_pkg;
    localparam int DEF_NUM_CH  = 24;
    localparam int DEF_CH_BITS = 8;
    localparam int DEF_REG_W   = 8;
    localparam int DEF_ADDR_W  = 8;
    localparam int NUM_SIDES   = 2;
    localparam int SIDE_RX     = 0;
    localparam int SIDE_TX     = 1;
endpackage

// File: rtl/chgate_pos_track.sv
// Module: bit position tracker for one side.
// Counts positions 0..FRAME_BITS-1 on each bit strobe. Position 0 is the
// framing bit. A strobe that comes with frame sync forces position 0.
// frame_start flags the strobe that enters position 0.
// Assumes the frame sync is only meaningful when it comes with bit_en.
module chgate_pos_track #(
    parameter int FRAME_BITS = 193,
    parameter int POS_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             fsync,
    output logic [POS_W-1:0] pos,
    output logic             frame_start
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

    // Flag the strobe that moves the counter onto the framing bit.
    always_comb begin
        frame_start = bit_en && (fsync || (pos == LAST_POS));
    end

    // Advance, wrap or resynchronise the position counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (frame_start) begin
            pos <= '0;
        end else if (bit_en) begin
            pos <= pos + POS_W'(1);
        end
    end

    // A strobe with frame sync lands on the framing bit (R6).
    p_sync_to_fbit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && fsync) |=> (pos == '0));

    // The last position wraps to the framing bit (R7).
    p_wrap_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !fsync && pos == LAST_POS) |=> (pos == '0));

    // No strobe, no movement (R7).
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(pos));

    // The counter never goes beyond the frame (R7).
    p_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= LAST_POS);
endmodule

// File: rtl/chgate_mask_bank.sv
// Module: mask register bank for one side.
// Holds NUM_REGS staged bytes at BASE..BASE+NUM_REGS-1. The working mask is
// loaded from the staged bytes only when load is high (the frame boundary).
// Channel n uses bit n-1 of the working mask, LSB-first across the bytes.
// Assumes NUM_CH is a whole multiple of REG_W.
module chgate_mask_bank #(
    parameter int NUM_CH = 24,
    parameter int REG_W  = 8,
    parameter int ADDR_W = 8,
    parameter int BASE   = 'h6C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              load,
    output logic [NUM_CH-1:0] active
);
    localparam int NUM_REGS = NUM_CH / REG_W;

    logic [NUM_CH-1:0] staged;

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_byte
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE + k);
        logic hit;

        // Decode this byte's address.
        always_comb begin
            hit = wr_en && (wr_addr == MY_ADDR);
        end

        // Capture software writes into the staged byte.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                staged[k*REG_W +: REG_W] <= '0;
            end else if (hit) begin
                staged[k*REG_W +: REG_W] <= wr_data;
            end
        end
    end

    // Move the staged mask into service on the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= '0;
        end else if (load) begin
            active <= staged;
        end
    end

    // The working mask changes only at a frame boundary (R8).
    p_load_only_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(active));

    // The working mask takes the staged value present at the boundary (R8).
    p_load_copies_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (active == $past(staged)));
endmodule

// File: rtl/chgate_gate_dec.sv
// Module: gating decode for one side.
// Outputs high when the position lies inside a channel whose working mask
// bit is set. The output is low on the framing bit at position 0.
// Assumes positions 1..NUM_CH*CH_BITS carry channels in ascending order.
module chgate_gate_dec #(
    parameter int NUM_CH  = 24,
    parameter int CH_BITS = 8,
    parameter int POS_W   = 8
) (
    input  logic [POS_W-1:0]  pos,
    input  logic [NUM_CH-1:0] mask,
    output logic              blk
);
    localparam int CH_W = $clog2(NUM_CH);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_CH * CH_BITS);

    logic [POS_W-1:0] offset;
    logic [POS_W-1:0] chan;

    // Map a position to its channel index and pick that channel's mask bit.
    always_comb begin
        offset = pos - POS_W'(1);
        chan   = offset / POS_W'(CH_BITS);
        blk    = 1'b0;
        if (pos != '0 && pos <= LAST_POS) begin
            blk = mask[chan[CH_W-1:0]];
        end
    end
endmodule

// File: rtl/chgate_top.sv
// Module: per-channel gating level generator, receive and transmit sides.
// Each side has a position tracker, a mask bank and a decode. The mask bank
// loads its working mask when its tracker enters the framing bit.
// Assumes both strobes are synchronous to clk. Reset is synchronous, active low.
module chgate_top #(
    parameter int NUM_CH  = chgate_pkg::DEF_NUM_CH,
    parameter int CH_BITS = chgate_pkg::DEF_CH_BITS,
    parameter int REG_W   = chgate_pkg::DEF_REG_W,
    parameter int ADDR_W  = chgate_pkg::DEF_ADDR_W,
    parameter int RX_BASE = 'h6C,
    parameter int TX_BASE = 'h32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rx_bit_en,
    input  logic              rx_fsync,
    input  logic              tx_bit_en,
    input  logic              tx_fsync,
    output logic              rx_blk,
    output logic              tx_blk
);
    import chgate_pkg::*;

    localparam int FRAME_BITS = NUM_CH * CH_BITS + 1;
    localparam int POS_W      = $clog2(FRAME_BITS);

    logic [NUM_SIDES-1:0] side_bit_en;
    logic [NUM_SIDES-1:0] side_fsync;
    logic [NUM_SIDES-1:0] side_blk;

    // Gather the per-side strobes into vectors.
    always_comb begin
        side_bit_en[SIDE_RX] = rx_bit_en;
        side_bit_en[SIDE_TX] = tx_bit_en;
        side_fsync[SIDE_RX]  = rx_fsync;
        side_fsync[SIDE_TX]  = tx_fsync;
    end

    assign rx_blk = side_blk[SIDE_RX];
    assign tx_blk = side_blk[SIDE_TX];

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        localparam int BASE = (s == SIDE_RX) ? RX_BASE : TX_BASE;

        logic [POS_W-1:0]  pos;
        logic              frame_start;
        logic [NUM_CH-1:0] active;

        chgate_pos_track #(
            .FRAME_BITS(FRAME_BITS),
            .POS_W     (POS_W)
        ) u_track (
            .clk        (clk),
            .rst_n      (rst_n),
            .bit_en     (side_bit_en[s]),
            .fsync      (side_fsync[s]),
            .pos        (pos),
            .frame_start(frame_start)
        );

        chgate_mask_bank #(
            .NUM_CH(NUM_CH),
            .REG_W (REG_W),
            .ADDR_W(ADDR_W),
            .BASE  (BASE)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en),
            .wr_addr(wr_addr),
            .wr_data(wr_data),
            .load   (frame_start),
            .active (active)
        );

        chgate_gate_dec #(
            .NUM_CH (NUM_CH),
            .CH_BITS(CH_BITS),
            .POS_W  (POS_W)
        ) u_dec (
            .pos (pos),
            .mask(active),
            .blk (side_blk[s])
        );

        // The framing bit is never gated open (R5).
        p_fbit_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (pos == '0) |-> !side_blk[s]);

        // Without a strobe the level holds across the channel (R3).
        p_steady_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !side_bit_en[s] |=> $stable(side_blk[s]));
    end
endmodule

// File: tb/chgate_top_test.sv
// Bench: random strobes, syncs and writes mixed with directed cases. A model
// built from the requirements is compared with both outputs every cycle.
module chgate_top_test;
    localparam int FRAME = 193;
    localparam int RXB = 'h6C;
    localparam int TXB = 'h32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] ben = '0;
    logic [1:0] fs = '0;
    logic       rx_blk, tx_blk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    string phase = "R1";

    int          m_pos [2];
    logic [23:0] m_stage [2];
    logic [23:0] m_act [2];

    always #5 clk = ~clk;

    chgate_top uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rx_bit_en(ben[0]), .rx_fsync(fs[0]),
        .tx_bit_en(ben[1]), .tx_fsync(fs[1]), .rx_blk(rx_blk), .tx_blk(tx_blk)
    );

    function automatic logic exp_blk(int pos, logic [23:0] m);
        if (pos == 0) return 1'b0;
        return m[(pos - 1) / 8];
    endfunction

    function automatic string pos_tag(int pos, logic [23:0] m);
        if (pos == 0) return "R5";
        if (m[(pos - 1) / 8]) return "R3";
        return "R4";
    endfunction

    // Reference model, updated from the requirement text (R2 R6 R7 R8 R9).
    always @(posedge clk) begin
        for (int s = 0; s < 2; s++) begin
            if (!rst_n) begin
                m_pos[s] <= 0; m_stage[s] <= '0; m_act[s] <= '0;
            end else begin
                int base;
                logic [23:0] st;
                base = (s == 0) ? RXB : TXB;
                st = m_stage[s];
                for (int k = 0; k < 3; k++)
                    if (wr_en && int'(wr_addr) == base + k) st[k*8 +: 8] = wr_data;
                m_stage[s] <= st;
                if (ben[s]) begin
                    if (fs[s] || m_pos[s] == FRAME - 1) begin
                        m_pos[s] <= 0;
                        m_act[s] <= m_stage[s];
                    end else begin
                        m_pos[s] <= m_pos[s] + 1;
                    end
                end
            end
        end
    end

    task automatic compare();
        logic got [2];
        got[0] = rx_blk; got[1] = tx_blk;
        for (int s = 0; s < 2; s++) begin
            logic e;
            e = rst_n ? exp_blk(m_pos[s], m_act[s]) : 1'b0;
            n_chk++;
            if (got[s] !== e) begin
                n_bad++;
                $display("FAIL %s %s side=%0d pos=%0d actual=%b expected=%b",
                         phase, pos_tag(m_pos[s], m_act[s]), s, m_pos[s], got[s], e);
            end
        end
    endtask

    // One cycle: check at the falling edge, then drive the next inputs.
    task automatic step(logic [1:0] b, logic [1:0] f, logic we, int a, int d);
        @(negedge clk);
        compare();
        ben = b; fs = f; wr_en = we; wr_addr = 8'(a); wr_data = 8'(d);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(2'b11, 2'b00, 1'b0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        // R1: outputs low during and after reset.
        phase = "R1";
        for (int i = 0; i < 4; i++) step(2'b11, 2'b11, 1'b0, 0, 0);
        @(negedge clk); rst_n = 1'b1;
        idle(400);

        // R2: one channel per side, the first and the last.
        phase = "R2";
        step(2'b00, 2'b00, 1'b1, RXB, 8'h01);
        step(2'b00, 2'b00, 1'b1, TXB + 2, 8'h80);
        step(2'b11, 2'b11, 1'b0, 0, 0);
        idle(400);
        step(2'b00, 2'b00, 1'b1, RXB + 1, 8'h10);
        step(2'b00, 2'b00, 1'b1, TXB + 1, 8'h03);
        idle(400);

        // R8: write exactly on the boundary strobe, deferred one frame.
        phase = "R8";
        step(2'b11, 2'b11, 1'b1, RXB, 8'hFF);
        idle(200);
        step(2'b11, 2'b11, 1'b1, TXB, 8'hAA);
        idle(400);

        // R6: resync in mid frame.
        phase = "R6";
        idle(37);
        step(2'b01, 2'b01, 1'b0, 0, 0);
        idle(90);
        step(2'b10, 2'b10, 1'b0, 0, 0);
        idle(300);

        // R7: sparse strobes, free-running wrap with no sync.
        phase = "R7";
        for (int i = 0; i < 2000; i++)
            step(2'(($urandom % 3 == 0) ? 2'b11 : 2'b00), 2'b00, 1'b0, 0, 0);

        // R9: writes to unrelated addresses change nothing.
        phase = "R9";
        for (int i = 0; i < 400; i++) begin
            int a;
            a = $urandom % 256;
            if ((a >= RXB && a < RXB + 3) || (a >= TXB && a < TXB + 3)) a = 'h00;
            step(2'b11, 2'b00, 1'b1, a, $urandom % 256);
        end

        // Random mix of all stimulus.
        phase = "R3";
        for (int i = 0; i < 12000; i++) begin
            logic [1:0] b, f;
            int a;
            b = 2'($urandom % 4);
            f = 2'(($urandom % 300 == 0) ? ($urandom % 4) : 0);
            case ($urandom % 4)
                0: a = RXB + int'($urandom % 3);
                1: a = TXB + int'($urandom % 3);
                default: a = $urandom % 256;
            endcase
            step(b, f, ($urandom % 40 == 0), a, $urandom % 256);
        end

        // R4: clear every mask and confirm all low after a boundary.
        phase = "R4";
        for (int k = 0; k < 3; k++) begin
            step(2'b00, 2'b00, 1'b1, RXB + k, 0);
            step(2'b00, 2'b00, 1'b1, TXB + k, 0);
        end
        step(2'b11, 2'b11, 1'b0, 0, 0);
        idle(400);

        @(negedge clk);
        compare();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired in phase %s actual=running expected=finished", phase);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule